// File: doc/BRIEF.md
# Qualified Performance Event Counter

This block is one programmable performance counter for a processor core. Every cycle it receives the number of times a monitored event happened, the current privilege level and the transactional-execution status. A configuration register selects which cycles qualify. The options are privilege filtering, a count threshold with optional inversion or rising-edge detection, and counting only inside a transaction. The block then adds either the raw occurrence count or a single cycle count to a 48-bit accumulator.

Software can overwrite the accumulator at any time and sees a sticky wrap flag. When rollback is enabled, the block snapshots the accumulator at the start of a transaction. It restores that snapshot on an abort pulse, so counts made inside a failed transaction leave no trace. The snapshot is dropped when the transaction ends normally.

Top module: `qual_evt_counter`

## Requirements
- R1: A counter write (`cnt_we`) loads `cnt_wdata` on the next edge. It wins over any increment or rollback in the same cycle, and it cancels a pending transaction snapshot, so a later abort does not restore.
- R2: Nothing is counted unless the global enable (config bit 14) is 1 and the privilege filter matches. Bit 9 admits level 0 and bit 8 admits levels 1 to 3.
- R3: With a threshold (bits 7:0) of 0 and edge mode (bit 11) clear, each qualifying cycle adds the raw `evt_cnt`. The invert bit (bit 10) has no effect in this mode.
- R4: With a nonzero threshold, a qualifying cycle adds 1 when `evt_cnt` is at least the threshold, and adds 0 otherwise.
- R5: With a nonzero threshold and invert set, a qualifying cycle adds 1 exactly when `evt_cnt` is below the threshold.
- R6: With edge mode and a nonzero threshold, 1 is added only in a cycle whose condition holds while the condition of the previous cycle did not.
- R7: Edge mode with a threshold of 0 drives `cfg_invalid` high, and the counter does not advance while that configuration is held.
- R8: With the in-transaction bit (bit 12) set, only cycles with `in_txn` high are counted.
- R9: With the rollback bit (bit 13) set, an abort pulse during a transaction returns the counter to its value from just before the cycle in which `in_txn` rose.
- R10: When `in_txn` falls without an abort, the snapshot is discarded, and a later abort leaves the counter unchanged.
- R11: The counter wraps modulo 2^48. A wrap sets `ovf_flag`, which stays set until an `ovf_clr` cycle without a new wrap.
- R12: After reset the counter, `ovf_flag`, `cfg_invalid` and all configuration bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_cnt | input | 8 | Event occurrences in this cycle |
| priv_lvl | input | 2 | Current privilege level, 0 is most privileged |
| in_txn | input | 1 | High while executing inside a transaction |
| txn_abort | input | 1 | One-cycle pulse: the current transaction aborted |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 15 | Configuration word |
| cnt_we | input | 1 | Counter write strobe |
| cnt_wdata | input | 48 | Counter write value |
| ovf_clr | input | 1 | Clear the wrap flag |
| cnt_value | output | 48 | Current counter value |
| ovf_flag | output | 1 | Sticky wrap flag |
| cfg_invalid | output | 1 | Edge mode is set with a zero threshold |

## Verification
The counter is visible directly on `cnt_value`. A wrong qualification decision therefore shows up as a deviation one edge after the cycle that caused it, and it persists, because every later value is off by the same amount. The edge-history and transaction-start flops are hidden, but an error in either one appears within a cycle or two: an extra or missing increment after a threshold crossing, or a restore to the wrong value at the next abort. A stale snapshot after a commit or a counter write only appears when a later abort rewinds the counter, so the stimulus places aborts after both events.

// File: rtl/qec_pkg.sv
package qec_pkg;
   localparam int MASK_W = 8;

   typedef struct packed {
      logic             en;        // 14
      logic             rollback;  // 13
      logic             txn_only;  // 12
      logic             edge_det;  // 11
      logic             inv;       // 10
      logic             lvl0_en;   // 9
      logic             lvl123_en; // 8
      logic [MASK_W-1:0] thresh;   // 7:0
   } cfg_t;

   localparam int CFG_W = $bits(cfg_t);
endpackage

// File: rtl/qec_cfg_reg.sv
module qec_cfg_reg
   import qec_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [CFG_W-1:0] wdata,
   output cfg_t             cfg,
   output logic             invalid
);
   cfg_t cfg_q;

   always_ff @(posedge clk) begin
      if (!rst_n)  cfg_q <= '0;
      else if (we) cfg_q <= cfg_t'(wdata);
   end

   assign cfg     = cfg_q;
   assign invalid = cfg_q.edge_det & (cfg_q.thresh == '0);
endmodule

// File: rtl/qec_qualifier.sv
module qec_qualifier
   import qec_pkg::*;
#(
   parameter int EVT_W   = 8,
   parameter bit HAS_TXN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  cfg_t             cfg,
   input  logic             invalid,
   input  logic [EVT_W-1:0] evt_cnt,
   input  logic [1:0]       priv_lvl,
   input  logic             in_txn,
   output logic [EVT_W-1:0] inc
);
   localparam int CMP_W = (EVT_W > MASK_W) ? EVT_W : MASK_W;

   logic [CMP_W-1:0] evt_x, thr_x;
   logic             hit, cond, prev_cond_q, priv_ok, txn_ok, gate, raw_mode;

   assign evt_x    = CMP_W'(evt_cnt);
   assign thr_x    = CMP_W'(cfg.thresh);
   assign raw_mode = (cfg.thresh == '0);
   assign cond     = (evt_x >= thr_x) ^ cfg.inv;
   assign priv_ok  = (priv_lvl == 2'd0) ? cfg.lvl0_en : cfg.lvl123_en;

   generate
      if (HAS_TXN) begin : g_txn_filter
         assign txn_ok = ~cfg.txn_only | in_txn;
      end else begin : g_no_txn_filter
         assign txn_ok = 1'b1;
      end
   endgenerate

   assign gate = cfg.en & priv_ok & txn_ok & ~invalid;

   // history of the threshold condition, tracked every cycle
   always_ff @(posedge clk) begin
      if (!rst_n) prev_cond_q <= 1'b0;
      else        prev_cond_q <= cond;
   end

   assign hit = cfg.edge_det ? (cond & ~prev_cond_q) : cond;

   always_comb begin
      if (!gate)         inc = '0;
      else if (raw_mode) inc = evt_cnt;
      else               inc = EVT_W'(hit);
   end
endmodule

// File: rtl/qec_counter.sv
module qec_counter #(
   parameter int CNT_W   = 48,
   parameter int EVT_W   = 8,
   parameter bit HAS_TXN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [EVT_W-1:0] inc,
   input  logic             sw_we,
   input  logic [CNT_W-1:0] sw_wdata,
   input  logic             ovf_clr,
   input  logic             in_txn,
   input  logic             txn_abort,
   input  logic             rollback_en,
   output logic [CNT_W-1:0] cnt,
   output logic             ovf
);
   logic [CNT_W-1:0] cnt_q, ckpt_val;
   logic [CNT_W:0]   sum_w;
   logic             ovf_q, do_restore, wrap;

   assign sum_w = {1'b0, cnt_q} + (CNT_W+1)'(inc);

   generate
      if (HAS_TXN) begin : g_ckpt
         logic [CNT_W-1:0] ckpt_q;
         logic             ckpt_v_q, txn_q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               ckpt_q   <= '0;
               ckpt_v_q <= 1'b0;
               txn_q    <= 1'b0;
            end else begin
               txn_q <= in_txn;
               if (sw_we || txn_abort) begin
                  ckpt_v_q <= 1'b0;
               end else if (in_txn && !txn_q) begin
                  ckpt_q   <= cnt_q;
                  ckpt_v_q <= 1'b1;
               end else if (!in_txn) begin
                  ckpt_v_q <= 1'b0;
               end
            end
         end

         assign do_restore = ckpt_v_q & txn_abort & rollback_en;
         assign ckpt_val   = ckpt_q;
      end else begin : g_no_ckpt
         assign do_restore = 1'b0;
         assign ckpt_val   = '0;
      end
   endgenerate

   assign wrap = ~sw_we & ~do_restore & sum_w[CNT_W];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         ovf_q <= 1'b0;
      end else begin
         if (sw_we)           cnt_q <= sw_wdata;
         else if (do_restore) cnt_q <= ckpt_val;
         else                 cnt_q <= sum_w[CNT_W-1:0];
         if (wrap)            ovf_q <= 1'b1;
         else if (ovf_clr)    ovf_q <= 1'b0;
      end
   end

   assign cnt = cnt_q;
   assign ovf = ovf_q;

   AST_SW_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      sw_we |=> cnt_q == $past(sw_wdata)); // R1
   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_q && !ovf_clr) |=> ovf_q); // R11
   AST_WRAP_SETS_OVF: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(sw_we) && !$past(txn_abort) && (cnt_q < $past(cnt_q))) |-> ovf_q); // R11
endmodule

// File: rtl/qual_evt_counter.sv
module qual_evt_counter #(
   parameter int CNT_W   = 48,
   parameter int EVT_W   = 8,
   parameter int CFG_W   = 15,
   parameter bit HAS_TXN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [EVT_W-1:0] evt_cnt,
   input  logic [1:0]       priv_lvl,
   input  logic             in_txn,
   input  logic             txn_abort,
   input  logic             cfg_we,
   input  logic [CFG_W-1:0] cfg_wdata,
   input  logic             cnt_we,
   input  logic [CNT_W-1:0] cnt_wdata,
   input  logic             ovf_clr,
   output logic [CNT_W-1:0] cnt_value,
   output logic             ovf_flag,
   output logic             cfg_invalid
);
   import qec_pkg::*;

   initial begin
      assert (CNT_W > EVT_W) else $error("counter must be wider than event input");
      assert (EVT_W >= 1)    else $error("event input width must be positive");
      assert (CFG_W == qec_pkg::CFG_W) else $error("config width mismatch");
   end

   cfg_t             cfg_q;
   logic [EVT_W-1:0] inc;

   qec_cfg_reg u_cfg (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata),
      .cfg(cfg_q), .invalid(cfg_invalid)
   );

   qec_qualifier #(.EVT_W(EVT_W), .HAS_TXN(HAS_TXN)) u_qual (
      .clk(clk), .rst_n(rst_n), .cfg(cfg_q), .invalid(cfg_invalid),
      .evt_cnt(evt_cnt), .priv_lvl(priv_lvl), .in_txn(in_txn), .inc(inc)
   );

   qec_counter #(.CNT_W(CNT_W), .EVT_W(EVT_W), .HAS_TXN(HAS_TXN)) u_cnt (
      .clk(clk), .rst_n(rst_n), .inc(inc), .sw_we(cnt_we), .sw_wdata(cnt_wdata),
      .ovf_clr(ovf_clr), .in_txn(in_txn), .txn_abort(txn_abort),
      .rollback_en(cfg_q.rollback), .cnt(cnt_value), .ovf(ovf_flag)
   );

   AST_INVALID_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_invalid && !cnt_we && !txn_abort) |=> $stable(cnt_value)); // R7
   AST_DISABLED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_q.en && !cnt_we && !txn_abort) |=> $stable(cnt_value)); // R2
endmodule

// File: tb/qual_evt_counter_bench.sv
`timescale 1ns/1ps
module qual_evt_counter_bench;
   localparam int CNT_W = 48;
   localparam int EVT_W = 8;
   localparam int CFG_W = 15;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [EVT_W-1:0] evt_cnt = '0;
   logic [1:0]       priv_lvl = '0;
   logic             in_txn = 1'b0, txn_abort = 1'b0;
   logic             cfg_we = 1'b0, cnt_we = 1'b0, ovf_clr = 1'b0;
   logic [CFG_W-1:0] cfg_wdata = '0;
   logic [CNT_W-1:0] cnt_wdata = '0;
   logic [CNT_W-1:0] cnt_value;
   logic             ovf_flag, cfg_invalid;

   always #10 clk = ~clk; // 50 MHz

   qual_evt_counter u_qual_evt_counter (
      .clk(clk), .rst_n(rst_n), .evt_cnt(evt_cnt), .priv_lvl(priv_lvl),
      .in_txn(in_txn), .txn_abort(txn_abort), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .cnt_we(cnt_we), .cnt_wdata(cnt_wdata), .ovf_clr(ovf_clr),
      .cnt_value(cnt_value), .ovf_flag(ovf_flag), .cfg_invalid(cfg_invalid)
   );

   int checks = 0, failures = 0;

   // scoreboard queues
   logic [CNT_W-1:0] q_cnt[$];
   logic             q_ovf[$];
   logic             q_inv[$];
   string            q_tag[$];

   // reference model state
   logic [CNT_W-1:0] m_cnt = '0, m_ckpt = '0;
   logic             m_ckv = 1'b0, m_ovf = 1'b0, m_prev = 1'b0, m_txq = 1'b0;
   logic [CFG_W-1:0] m_cfg = '0;

   // config field helpers (R2..R9 bit positions)
   localparam logic [CFG_W-1:0] EN = 15'h4000, RB = 15'h2000, TX = 15'h1000,
                                ED = 15'h0800, IV = 15'h0400, K0 = 15'h0200, US = 15'h0100;

   task automatic cycle(input logic [7:0] ev, input logic [1:0] pl, input logic tx,
                        input logic ab, input logic cwe, input logic [CFG_W-1:0] cd,
                        input logic nwe, input logic [CNT_W-1:0] nd, input logic oc,
                        input string tag);
      logic [7:0] thr;
      logic cond, gate, begin_t, restore, inv_cfg;
      logic [7:0] inc;
      logic [CNT_W:0] s;
      @(negedge clk);
      evt_cnt = ev; priv_lvl = pl; in_txn = tx; txn_abort = ab; cfg_we = cwe;
      cfg_wdata = cd; cnt_we = nwe; cnt_wdata = nd; ovf_clr = oc;
      thr     = m_cfg[7:0];
      inv_cfg = m_cfg[11] && (thr == 0);
      cond    = (ev >= thr) ^ m_cfg[10];
      gate    = m_cfg[14] && ((pl == 0) ? m_cfg[9] : m_cfg[8]) && (!m_cfg[12] || tx) && !inv_cfg;
      if (!gate)         inc = 0;
      else if (thr == 0) inc = ev;
      else if (m_cfg[11]) inc = {7'd0, cond && !m_prev};
      else               inc = {7'd0, cond};
      begin_t = tx && !m_txq;
      restore = ab && m_ckv && m_cfg[13];
      s = {1'b0, m_cnt} + (CNT_W+1)'(inc);
      if (nwe)          m_cnt = nd;
      else if (restore) m_cnt = m_ckpt;
      else begin
         if (s[CNT_W]) m_ovf = 1'b1;
         m_cnt = s[CNT_W-1:0];
      end
      if (!(!nwe && !restore && s[CNT_W]) && oc) m_ovf = 1'b0;
      if (nwe || ab)    m_ckv = 1'b0;
      else if (begin_t) begin m_ckpt = m_cnt - (CNT_W)'(inc); m_ckv = 1'b1; end
      else if (!tx)     m_ckv = 1'b0;
      m_prev = cond; m_txq = tx;
      if (cwe) m_cfg = cd;
      q_cnt.push_back(m_cnt);
      q_ovf.push_back(m_ovf);
      q_inv.push_back(m_cfg[11] && (m_cfg[7:0] == 0));
      q_tag.push_back(tag);
   endtask

   task automatic ev_cyc(input logic [7:0] ev, input logic [1:0] pl, input logic tx,
                         input logic ab, input string tag);
      cycle(ev, pl, tx, ab, 1'b0, '0, 1'b0, '0, 1'b0, tag);
   endtask

   task automatic wr_cfg(input logic [CFG_W-1:0] cd, input string tag);
      cycle(8'd0, 2'd3, 1'b0, 1'b0, 1'b1, cd, 1'b0, '0, 1'b0, tag);
   endtask

   // monitor: compare one expected item per clock edge
   always @(posedge clk) begin
      #2;
      if (q_cnt.size() > 0) begin
         logic [CNT_W-1:0] ec;
         logic eo, ei;
         string t;
         ec = q_cnt.pop_front(); eo = q_ovf.pop_front(); ei = q_inv.pop_front(); t = q_tag.pop_front();
         checks++;
         if (cnt_value !== ec || ovf_flag !== eo || cfg_invalid !== ei) begin
            failures++;
            $display("FAIL %s: cnt=%0h ovf=%0b inv=%0b expected cnt=%0h ovf=%0b inv=%0b",
                     t, cnt_value, ovf_flag, cfg_invalid, ec, eo, ei);
         end
      end
   end

   initial begin
      #4000000;
      failures++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #2;
      checks++; // R12 reset state
      if (cnt_value !== '0 || ovf_flag !== 1'b0 || cfg_invalid !== 1'b0) begin
         failures++;
         $display("FAIL R12: cnt=%0h ovf=%0b inv=%0b expected 0 0 0", cnt_value, ovf_flag, cfg_invalid);
      end
      @(negedge clk); rst_n = 1'b1;
      ev_cyc(8'd5, 2'd3, 1'b0, 1'b0, "R12 config zero after reset");

      // R3 raw mode, invert ignored
      wr_cfg(EN | US | K0, "R3 cfg");
      ev_cyc(8'd3, 2'd3, 0, 0, "R3 raw add 3");
      ev_cyc(8'd7, 2'd0, 0, 0, "R3 raw add 7");
      wr_cfg(EN | US | K0 | IV, "R3 cfg inv");
      ev_cyc(8'd4, 2'd1, 0, 0, "R3 invert ignored");

      // R2 privilege and enable filtering
      wr_cfg(EN | US, "R2 cfg user");
      ev_cyc(8'd9, 2'd0, 0, 0, "R2 level0 blocked");
      ev_cyc(8'd2, 2'd2, 0, 0, "R2 level2 counts");
      wr_cfg(EN | K0, "R2 cfg kernel");
      ev_cyc(8'd6, 2'd3, 0, 0, "R2 level3 blocked");
      ev_cyc(8'd6, 2'd0, 0, 0, "R2 level0 counts");
      wr_cfg(US | K0, "R2 cfg disabled");
      ev_cyc(8'd6, 2'd0, 0, 0, "R2 global off");

      // R4 threshold
      wr_cfg(EN | US | 15'd4, "R4 cfg thr4");
      ev_cyc(8'd3, 2'd3, 0, 0, "R4 below threshold");
      ev_cyc(8'd4, 2'd3, 0, 0, "R4 equal threshold");
      ev_cyc(8'd200, 2'd3, 0, 0, "R4 above threshold");

      // R5 invert
      wr_cfg(EN | US | IV | 15'd4, "R5 cfg");
      ev_cyc(8'd3, 2'd3, 0, 0, "R5 below counts");
      ev_cyc(8'd5, 2'd3, 0, 0, "R5 above blocked");

      // R6 edge
      wr_cfg(EN | US | ED | 15'd4, "R6 cfg");
      ev_cyc(8'd5, 2'd3, 0, 0, "R6 first edge");
      ev_cyc(8'd5, 2'd3, 0, 0, "R6 held no add");
      ev_cyc(8'd0, 2'd3, 0, 0, "R6 fall");
      ev_cyc(8'd6, 2'd3, 0, 0, "R6 second edge");

      // R7 invalid
      wr_cfg(EN | US | ED, "R7 cfg invalid");
      ev_cyc(8'd5, 2'd3, 0, 0, "R7 no count");
      ev_cyc(8'd0, 2'd3, 0, 0, "R7 no count low");
      ev_cyc(8'd9, 2'd3, 0, 0, "R7 no count again");

      // R8 transaction-only
      wr_cfg(EN | US | TX, "R8 cfg");
      ev_cyc(8'd4, 2'd3, 0, 0, "R8 outside blocked");
      ev_cyc(8'd4, 2'd3, 1, 0, "R8 inside counts");
      ev_cyc(8'd2, 2'd3, 0, 0, "R8 outside again");

      // R9 rollback on abort
      wr_cfg(EN | US | RB, "R9 cfg");
      ev_cyc(8'd3, 2'd3, 0, 0, "R9 pre-txn");
      ev_cyc(8'd5, 2'd3, 1, 0, "R9 txn start");
      ev_cyc(8'd7, 2'd3, 1, 0, "R9 txn body");
      ev_cyc(8'd9, 2'd3, 1, 1, "R9 abort restores");
      ev_cyc(8'd1, 2'd3, 0, 0, "R9 after abort");

      // R10 commit discards snapshot
      ev_cyc(8'd4, 2'd3, 1, 0, "R10 txn start");
      ev_cyc(8'd4, 2'd3, 0, 0, "R10 commit");
      ev_cyc(8'd2, 2'd3, 0, 1, "R10 late abort no restore");

      // R1 write priority and snapshot cancel
      cycle(8'd9, 2'd3, 0, 0, 0, '0, 1, 48'h1234, 0, "R1 write beats increment");
      ev_cyc(8'd2, 2'd3, 1, 0, "R1 txn start");
      cycle(8'd2, 2'd3, 1, 0, 0, '0, 1, 48'h500, 0, "R1 write inside txn");
      ev_cyc(8'd3, 2'd3, 1, 0, "R1 txn continues");
      ev_cyc(8'd3, 2'd3, 1, 1, "R1 abort after write no restore");
      cycle(8'd0, 2'd3, 1, 1, 0, '0, 1, 48'h77, 0, "R1 write beats restore");
      ev_cyc(8'd0, 2'd3, 0, 0, "R1 idle");

      // R11 wrap and sticky flag
      cycle(8'd0, 2'd3, 0, 0, 0, '0, 1, 48'hFFFF_FFFF_FFFD, 0, "R11 preload");
      ev_cyc(8'd5, 2'd3, 0, 0, "R11 wrap sets flag");
      ev_cyc(8'd1, 2'd3, 0, 0, "R11 flag sticky");
      cycle(8'd0, 2'd3, 0, 0, 0, '0, 0, '0, 1, "R11 clear flag");
      cycle(8'd0, 2'd3, 0, 0, 0, '0, 1, 48'hFFFF_FFFF_FFFF, 0, "R11 preload max");
      cycle(8'd1, 2'd3, 0, 0, 0, '0, 0, '0, 1, "R11 wrap beats clear");
      ev_cyc(8'd0, 2'd3, 0, 0, "R11 idle");

      repeat (3) @(posedge clk);
      #5;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule